// File: doc/BRIEF.md
# Guarded Two-Way Clock Divider Control Register

This block holds one byte-wide control register that sets the divide ratios of two power-of-two dividers running from a single input clock. One divider produces a one-cycle enable pulse for the system domain. The other produces a one-cycle enable pulse for the timer domain, and it can also be switched off completely. Logic downstream uses these pulses as clock enables. No clock is gated or switched here.

The select fields are protected. Software first writes a key value, which is bit 7 set and every other bit clear. This opens a short change window, and the register takes a new divider setting only while that window is open. The window closes after a fixed number of input clock cycles, or as soon as a setting is accepted. Writing the key again while the window is open neither lengthens nor ends it. Each divider applies a new ratio only when its current period finishes, so a ratio change never produces a truncated period.

Top module: `dual_prescale_ctl`

## Requirements
- R1: A write of exactly 0x80 (bit 7 set, bits 6:0 clear) while the window is closed opens the change window. Any other value never opens it. The open state reads back as bit 7.
- R2: Once the key is written, a write of any non-key value in the 1st to 4th input cycle after the key is accepted and closes the window at once. The same write in the 5th cycle or later is ignored. Bit 7 of an accepted write is ignored.
- R3: Writing the key again while the window is open does not restart the four-cycle count and does not close the window.
- R4: Bit 6 always reads as zero, whatever value was written to it.
- R5: Bits 5:3 select the timer ratio. Code 0 produces no timer pulses. Code c (1 to 7) produces a one-cycle pulse every 2^(c-1) input cycles.
- R6: Bits 2:0 select the system ratio. Code c (0 to 7) produces a one-cycle pulse every 2^c input cycles.
- R7: After reset the register reads 0x00, both select outputs are 0, the system pulse is present on every cycle, and the timer pulse is absent.
- R8: A non-key write while the window is closed leaves both select fields unchanged.
- R9: A new ratio takes effect only when the running period ends. The pulse interval that is in progress at the moment of the change keeps the old length.
- R10: While the read strobe is high, read data is {window, 0, timer select, system select}. Read data is 0x00 while the strobe is low. The select outputs always show the stored fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that both dividers count |
| rst_n | input | 1 | Active-low reset, applied at the clock edge |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational while rd_en is high |
| sys_sel | output | 3 | Stored system ratio code |
| tmr_sel | output | 3 | Stored timer ratio code |
| sys_en | output | 1 | System enable pulse |
| tmr_en | output | 1 | Timer enable pulse |

## Verification
The hardest case to reach from the ports is the edge of the window. A write that lands exactly on the 4th cycle after the key must be accepted, and the same write on the 5th cycle must be rejected. A second key write must also be shown not to push that edge back. The stimulus places writes and reads on exact cycle offsets from the key write, and a cycle-by-cycle run of reads shows the window flag falling on schedule after a second key write. A ratio change is applied just after a pulse at the slowest system ratio, so that the interval in progress can be seen finishing at its old length.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

   typedef enum logic [0:0] {
      DIV_PLAIN    = 1'b0,
      DIV_WITH_OFF = 1'b1
   } div_mode_e;

   function automatic int unsigned pcd_ctl_width(input int unsigned sel_w);
      return 2 * sel_w + 2;
   endfunction

endpackage

// File: rtl/pcd_unlock.sv
module pcd_unlock #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned WIN_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              open_o,
   output logic              fld_we_o
);

   localparam int unsigned WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
   localparam logic [DATA_W-1:0] KEY = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYC - 1);

   if (WIN_CYC < 1) begin : g_bad_win
      $error("pcd_unlock: WIN_CYC must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("pcd_unlock: DATA_W must be at least 2");
   end

   logic             open_q;
   logic [WIN_W-1:0] win_q;
   logic             is_key;
   logic             arm;

   assign is_key   = (wr_data_i == KEY);
   assign arm      = wr_en_i && is_key && !open_q;
   assign fld_we_o = wr_en_i && open_q && !is_key;
   assign open_o   = open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         win_q  <= '0;
      end else if (arm) begin
         open_q <= 1'b1;
         win_q  <= WIN_LOAD;
      end else if (open_q) begin
         if (fld_we_o || (win_q == '0)) begin
            open_q <= 1'b0;
            win_q  <= '0;
         end else begin
            win_q <= win_q - 1'b1;
         end
      end
   end

   assert_unlock_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_q && wr_en_i && wr_data_i == KEY) |=> open_o);

   assert_write_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && wr_en_i && wr_data_i != KEY) |=> !open_o);

   assert_rearm_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && wr_en_i && wr_data_i == KEY && win_q != '0) |=> (open_o && win_q == $past(win_q) - 1'b1));

endmodule

// File: rtl/pcd_ctl_fields.sv
module pcd_ctl_fields #(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [SEL_W-1:0]  sys_d_i,
   input  logic [SEL_W-1:0]  tmr_d_i,
   input  logic              open_i,
   input  logic              rd_en_i,
   output logic [SEL_W-1:0]  sys_q_o,
   output logic [SEL_W-1:0]  tmr_q_o,
   output logic [DATA_W-1:0] rd_data_o
);

   if (DATA_W != 2 * SEL_W + 2) begin : g_bad_layout
      $error("pcd_ctl_fields: DATA_W must equal 2*SEL_W+2");
   end

   logic [SEL_W-1:0] sys_q;
   logic [SEL_W-1:0] tmr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sys_q <= '0;
         tmr_q <= '0;
      end else if (we_i) begin
         sys_q <= sys_d_i;
         tmr_q <= tmr_d_i;
      end
   end

   assign sys_q_o   = sys_q;
   assign tmr_q_o   = tmr_q;
   assign rd_data_o = rd_en_i ? {open_i, 1'b0, tmr_q, sys_q} : '0;

endmodule

// File: rtl/pcd_divider.sv
module pcd_divider #(
   parameter int unsigned       SEL_W = 3,
   parameter pcd_pkg::div_mode_e MODE = pcd_pkg::DIV_PLAIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             en_o
);

   localparam int unsigned MAX_EXP = (1 << SEL_W) - 1;
   localparam int unsigned CNT_W   = MAX_EXP;
   localparam logic [SEL_W-1:0] MIN_CODE = (MODE == pcd_pkg::DIV_WITH_OFF) ? SEL_W'(1) : SEL_W'(0);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("pcd_divider: SEL_W must be between 1 and 4");
   end

   logic [SEL_W-1:0] act_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] shamt;
   logic             off;
   logic [CNT_W:0]   one_sh;
   logic [CNT_W-1:0] lim;
   logic             wrap;

   if (MODE == pcd_pkg::DIV_WITH_OFF) begin : g_off
      assign off   = (act_q == '0);
      assign shamt = act_q - 1'b1;
   end else begin : g_plain
      assign off   = 1'b0;
      assign shamt = act_q;
   end

   assign one_sh = (CNT_W+1)'(1) << shamt;
   assign lim    = one_sh[CNT_W-1:0] - CNT_W'(1);
   assign wrap   = (cnt_q == lim);
   assign en_o   = !off && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
      end else if (off || wrap) begin
         act_q <= sel_i;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_no_back2back_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && act_q != MIN_CODE && sel_i != MIN_CODE) |=> !en_o);

   if (MODE == pcd_pkg::DIV_WITH_OFF) begin : g_off_chk
      assert_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (act_q == '0 && sel_i == '0) |=> !en_o);
   end

endmodule

// File: rtl/dual_prescale_ctl.sv
module dual_prescale_ctl #(
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned WIN_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [SEL_W-1:0]  sys_sel,
   output logic [SEL_W-1:0]  tmr_sel,
   output logic              sys_en,
   output logic              tmr_en
);

   localparam int unsigned SYS_LO = 0;
   localparam int unsigned TMR_LO = SEL_W;

   if (DATA_W != pcd_pkg::pcd_ctl_width(SEL_W)) begin : g_bad_top
      $error("dual_prescale_ctl: DATA_W does not match SEL_W");
   end

   logic open;
   logic fld_we;

   pcd_unlock #(
      .DATA_W  (DATA_W),
      .WIN_CYC (WIN_CYC)
   ) u_unlock (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .open_o    (open),
      .fld_we_o  (fld_we)
   );

   pcd_ctl_fields #(
      .SEL_W  (SEL_W),
      .DATA_W (DATA_W)
   ) u_fields (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (fld_we),
      .sys_d_i   (wr_data[SYS_LO +: SEL_W]),
      .tmr_d_i   (wr_data[TMR_LO +: SEL_W]),
      .open_i    (open),
      .rd_en_i   (rd_en),
      .sys_q_o   (sys_sel),
      .tmr_q_o   (tmr_sel),
      .rd_data_o (rd_data)
   );

   pcd_divider #(
      .SEL_W (SEL_W),
      .MODE  (pcd_pkg::DIV_PLAIN)
   ) u_sys_div (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (sys_sel),
      .en_o  (sys_en)
   );

   pcd_divider #(
      .SEL_W (SEL_W),
      .MODE  (pcd_pkg::DIV_WITH_OFF)
   ) u_tmr_div (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (tmr_sel),
      .en_o  (tmr_en)
   );

   assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && wr_en) |=> ($stable(sys_sel) && $stable(tmr_sel)));

endmodule

// File: tb/tb_dual_prescale_ctl.sv
`timescale 1ns/1ps
module tb_dual_prescale_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [2:0] sys_sel;
   logic [2:0] tmr_sel;
   logic       sys_en;
   logic       tmr_en;

   always #2.5 clk = ~clk;

   dual_prescale_ctl dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .sys_sel (sys_sel),
      .tmr_sel (tmr_sel),
      .sys_en  (sys_en),
      .tmr_en  (tmr_en)
   );

   typedef struct {
      int    req;
      int    val;
      string what;
   } exp_t;

   exp_t sb[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   sys_last = 0, sys_gap = 0, tmr_last = 0, tmr_gap = 0, tmr_count = 0;
   event sys_ev, tmr_ev;

   always @(posedge clk) cyc++;

   task automatic push(input int req, input int val, input string what);
      exp_t e;
      e.req = req; e.val = val; e.what = what;
      sb.push_back(e);
   endtask

   task automatic compare(input int got);
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (got != e.val) begin
         errors++;
         $display("FAIL R%0d %s: got %0d (0x%0h) expected %0d (0x%0h)",
                  e.req, e.what, got, got, e.val, e.val);
      end
   endtask

   // monitor: samples 1 ns after each falling edge
   always @(negedge clk) begin
      #1;
      if (rd_en) compare(int'(rd_data));
      if (sys_en) begin
         sys_gap = cyc - sys_last; sys_last = cyc; ->sys_ev;
      end
      if (tmr_en) begin
         tmr_gap = cyc - tmr_last; tmr_last = cyc; tmr_count++; ->tmr_ev;
      end
   end

   // driver tasks, called at a falling edge, return at the next one
   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic rd(input logic [7:0] exp_v, input int req, input string what);
      push(req, int'(exp_v), what);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sys_period(input int exp_v, input int req, input string what);
      int g;
      push(req, exp_v, what);
      @(sys_ev); @(sys_ev); @(sys_ev);
      g = sys_gap;
      compare(g);
      @(negedge clk);
   endtask

   task automatic tmr_period(input int exp_v, input int req, input string what);
      int g;
      push(req, exp_v, what);
      @(tmr_ev); @(tmr_ev); @(tmr_ev);
      g = tmr_gap;
      compare(g);
      @(negedge clk);
   endtask

   task automatic tmr_silent(input int req, input string what);
      int s;
      s = tmr_count;
      idle(300);
      push(req, 0, what);
      compare(tmr_count - s);
   endtask

   task automatic set_codes(input logic [2:0] t, input logic [2:0] s);
      wr(8'h80);
      wr({2'b00, t, s});
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int g;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 reset state
      rd(8'h00, 7, "reset readback");
      push(7, 0, "reset sys_sel"); compare(int'(sys_sel));
      push(7, 0, "reset tmr_sel"); compare(int'(tmr_sel));
      sys_period(1, 7, "reset system period");
      tmr_silent(7, "reset timer off");

      // R10 idle read data
      push(10, 0, "read data with strobe low"); compare(int'(rd_data));

      // R8 locked write ignored
      wr(8'h15);
      rd(8'h00, 8, "locked write ignored");

      // R1 opening reads back bit 7
      wr(8'h80);
      rd(8'h80, 1, "window visible after key");
      idle(4);
      rd(8'h00, 1, "window gone after timeout");

      // R2 write on 4th cycle after key accepted
      wr(8'h80);
      idle(3);
      wr(8'h2B);
      rd(8'h2B, 2, "write at 4th cycle accepted, window closed");
      push(10, 3, "sys_sel output"); compare(int'(sys_sel));
      push(10, 5, "tmr_sel output"); compare(int'(tmr_sel));

      // R2 write on 5th cycle rejected
      wr(8'h80);
      idle(4);
      wr(8'h11);
      rd(8'h2B, 2, "write at 5th cycle ignored");

      // R1 wrong keys
      wr(8'h81); wr(8'h11);
      rd(8'h2B, 1, "key with bit 0 set does not open");
      wr(8'hC0); wr(8'h11);
      rd(8'h2B, 1, "key with bit 6 set does not open");
      wr(8'hA0); wr(8'h11);
      rd(8'h2B, 1, "key with bit 5 set does not open");

      // R3 second key inside window
      wr(8'h80);
      wr(8'h80);
      rd(8'hAB, 3, "window open after second key, cycle 2");
      rd(8'hAB, 3, "window open, cycle 3");
      rd(8'hAB, 3, "window open, cycle 4");
      rd(8'h2B, 3, "window not extended, cycle 5");

      // R2 bit 7 of an accepted write ignored
      wr(8'h80); wr(8'hB5);
      rd(8'h35, 2, "bit 7 of field write ignored");

      // R4 reserved bit
      wr(8'h80); wr(8'h40);
      rd(8'h00, 4, "bit 6 write reads zero");
      wr(8'h80); wr(8'h7F);
      rd(8'h3F, 4, "all-ones write, bit 6 zero");

      // R5 R6 every code
      for (int c = 0; c < 8; c++) begin
         set_codes(3'(c), 3'(c));
         sys_period(1 << c, 6, "system period for code");
         if (c == 0) tmr_silent(5, "timer code 0 silent");
         else        tmr_period(1 << (c - 1), 5, "timer period for code");
      end

      // R9 change applied at wrap
      set_codes(3'd0, 3'd7);
      @(sys_ev); @(sys_ev);
      @(negedge clk);
      set_codes(3'd0, 3'd0);
      push(9, 128, "interval in progress keeps old length");
      @(sys_ev);
      g = sys_gap;
      compare(g);
      push(9, 1, "new ratio after wrap");
      @(sys_ev);
      g = sys_gap;
      compare(g);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule